// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block sits beside the instruction fetch path of a small 8-bit processor and turns the operand bytes of an indexed instruction into a 16-bit effective address. Instruction bytes arrive one per cycle while a valid qualifier is high. An optional leading prefix byte selects the second index register instead of the first. An opcode byte follows, then an unsigned 8-bit displacement. The block zero-extends the displacement and adds it to the chosen index register. It raises a one-cycle strobe that carries the address and a flag naming the register it used.

The block also holds the two 16-bit index registers and an 8-bit accumulator. A load port writes each of them. A separate command adds the accumulator to the first index register in place, which allows a displacement computed at run time. Forming an address never writes an index register.

Top module: `idx_ea_gen`

## Requirements
- R1: When the displacement byte is accepted, the effective address is the selected index register plus the zero-extended displacement, taken modulo 2^16. The carry out of bit 15 is discarded.
- R2: The displacement is unsigned. A byte of 8'hFF adds 255 and never subtracts one.
- R3: Forming an effective address leaves both index registers unchanged. A later address with a zero displacement returns the earlier register value.
- R4: When the first byte is not the prefix, the instruction takes two bytes (opcode, displacement), uses index X, and reports `ea_used_y` = 0.
- R5: A first byte of 8'h18 is the prefix. The instruction then takes three bytes (prefix, opcode, displacement), uses index Y, and reports `ea_used_y` = 1. A value of 8'h18 in the opcode position is treated as an opcode.
- R6: A displacement byte of 8'h00 gives an effective address equal to the selected index register.
- R7: A one-cycle `abx_go` writes X + {8'h00, B} (mod 2^16) into X at the next clock edge.
- R8: `ea_valid` goes high for exactly one cycle, starting at the first clock edge after the displacement byte is sampled. `ea_addr` and `ea_used_y` are valid with it. At all other times `ea_valid` is 0.
- R9: A cycle with `byte_valid` low does not advance the byte sequence and produces no strobe.
- R10: Synchronous reset returns the sequencer to wait for a first byte, drops any pending prefix, clears `ea_valid`, and clears X, Y and B to zero.
- R11: `ld_x`, `ld_y` and `ld_b` write `ld_data` (B takes bits 7:0) at the next edge. `ld_x` overrides `abx_go` in the same cycle. An address formed in the same cycle as a register write uses the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | Qualifies `byte_in` this cycle |
| byte_in | input | 8 | Instruction byte |
| ld_x | input | 1 | Load X from `ld_data` |
| ld_y | input | 1 | Load Y from `ld_data` |
| ld_b | input | 1 | Load B from `ld_data[7:0]` |
| ld_data | input | 16 | Register load value |
| abx_go | input | 1 | Add B to X in place |
| ea_valid | output | 1 | One-cycle address strobe |
| ea_addr | output | 16 | Effective address |
| ea_used_y | output | 1 | 1 when Y formed the address, 0 for X |

## Verification
The hardest case to reach from the ports is a register write that coincides with acceptance of the displacement byte, because the address must use the value from before the write. The stimulus drives the displacement byte, an X load and an accumulator add on the same cycle. It then checks the strobe value, and a zero-displacement address that follows shows which write won. A prefix dropped by reset, and a prefix value placed in the opcode position, are each built as byte sequences with their own check.

// File: rtl/idx_pkg.sv
package idx_pkg;
   typedef enum logic [1:0] {
      SQ_FIRST = 2'd0,
      SQ_OPC   = 2'd1,
      SQ_OFS   = 2'd2
   } seq_state_t;
endpackage

// File: rtl/idx_seq.sv
module idx_seq #(
   parameter int         BYTE_W  = 8,
   parameter logic [7:0] PREBYTE = 8'h18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              take_ofs,
   output logic              sel_y
);
   import idx_pkg::*;

   initial begin
      if (BYTE_W != 8) $error("idx_seq: BYTE_W must be 8");
   end

   seq_state_t state, state_nx;
   logic       sel_y_nx;

   always_comb begin
      state_nx = state;
      sel_y_nx = sel_y;
      if (byte_valid) begin
         unique case (state)
            SQ_FIRST: begin
               if (byte_in == PREBYTE[BYTE_W-1:0]) begin
                  state_nx = SQ_OPC;
                  sel_y_nx = 1'b1;
               end else begin
                  state_nx = SQ_OFS;
                  sel_y_nx = 1'b0;
               end
            end
            SQ_OPC:  state_nx = SQ_OFS;
            SQ_OFS:  state_nx = SQ_FIRST;
            default: state_nx = SQ_FIRST;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SQ_FIRST;
         sel_y <= 1'b0;
      end else begin
         state <= state_nx;
         sel_y <= sel_y_nx;
      end
   end

   assign take_ofs = byte_valid && (state == SQ_OFS);

   AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      !byte_valid |=> $stable(state)) else $error("sequencer moved on idle cycle"); // R9
   AST_SEQ_RESET: assert property (@(posedge clk)
      rst |=> (state == SQ_FIRST && !sel_y)) else $error("reset did not clear sequencer"); // R10
   AST_SEQ_PREFIX: assert property (@(posedge clk) disable iff (rst)
      (byte_valid && state == SQ_FIRST && byte_in == PREBYTE[BYTE_W-1:0]) |=> (sel_y && state == SQ_OPC))
      else $error("prefix not taken"); // R5
endmodule

// File: rtl/idx_regs.sv
module idx_regs #(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_x,
   input  logic              ld_y,
   input  logic              ld_b,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic              abx_go,
   output logic [ADDR_W-1:0] x_q,
   output logic [ADDR_W-1:0] y_q,
   output logic [BYTE_W-1:0] b_q
);
   localparam int PAD_W = ADDR_W - BYTE_W;

   initial begin
      if (PAD_W <= 0) $error("idx_regs: ADDR_W must exceed BYTE_W");
   end

   logic [ADDR_W-1:0] abx_sum;
   assign abx_sum = x_q + {{PAD_W{1'b0}}, b_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
         y_q <= '0;
         b_q <= '0;
      end else begin
         if (ld_x)        x_q <= ld_data;
         else if (abx_go) x_q <= abx_sum;
         if (ld_y)        y_q <= ld_data;
         if (ld_b)        b_q <= ld_data[BYTE_W-1:0];
      end
   end

   AST_X_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!ld_x && !abx_go) |=> $stable(x_q)) else $error("X changed without a write"); // R3
   AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ld_y |=> $stable(y_q)) else $error("Y changed without a write"); // R3
   AST_ABX_SUM: assert property (@(posedge clk) disable iff (rst)
      (abx_go && !ld_x) |=> (x_q == $past(x_q) + {{PAD_W{1'b0}}, $past(b_q)}))
      else $error("ABX result wrong"); // R7
   AST_LD_WINS: assert property (@(posedge clk) disable iff (rst)
      ld_x |=> (x_q == $past(ld_data))) else $error("X load lost"); // R11
endmodule

// File: rtl/idx_adder.sv
module idx_adder #(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [BYTE_W-1:0] ofs,
   output logic [ADDR_W-1:0] sum
);
   localparam int PAD_W = ADDR_W - BYTE_W;

   initial begin
      if (PAD_W <= 0) $error("idx_adder: ADDR_W must exceed BYTE_W");
   end

   logic [ADDR_W:0] wide;
   assign wide = {1'b0, base} + {1'b0, {PAD_W{1'b0}}, ofs};
   assign sum  = wide[ADDR_W-1:0];
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen #(
   parameter int         ADDR_W  = 16,
   parameter int         BYTE_W  = 8,
   parameter logic [7:0] PREBYTE = 8'h18,
   parameter bit         OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              ld_x,
   input  logic              ld_y,
   input  logic              ld_b,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic              abx_go,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] ea_addr,
   output logic              ea_used_y
);
   localparam int PAD_W = ADDR_W - BYTE_W;

   initial begin
      if (ADDR_W != 16) $error("idx_ea_gen: ADDR_W must be 16");
      if (PAD_W <= 0)   $error("idx_ea_gen: ADDR_W must exceed BYTE_W");
   end

   logic              take_ofs;
   logic              sel_y;
   logic [ADDR_W-1:0] x_q, y_q, base, sum;
   logic [BYTE_W-1:0] b_q;

   idx_seq #(.BYTE_W(BYTE_W), .PREBYTE(PREBYTE)) u_seq (
      .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
      .take_ofs(take_ofs), .sel_y(sel_y)
   );

   idx_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst(rst), .ld_x(ld_x), .ld_y(ld_y), .ld_b(ld_b),
      .ld_data(ld_data), .abx_go(abx_go), .x_q(x_q), .y_q(y_q), .b_q(b_q)
   );

   assign base = sel_y ? y_q : x_q;

   idx_adder #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_add (
      .base(base), .ofs(byte_in), .sum(sum)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               ea_valid  <= 1'b0;
               ea_addr   <= '0;
               ea_used_y <= 1'b0;
            end else begin
               ea_valid <= take_ofs;
               if (take_ofs) begin
                  ea_addr   <= sum;
                  ea_used_y <= sel_y;
               end
            end
         end

         AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
            ea_valid |=> !ea_valid) else $error("strobe longer than one cycle"); // R8
         AST_EA_SUM: assert property (@(posedge clk) disable iff (rst)
            (byte_valid && take_ofs) |=> (ea_valid && ea_addr == $past(base) + {{PAD_W{1'b0}}, $past(byte_in)}))
            else $error("effective address wrong"); // R1
         AST_RESET_OUT: assert property (@(posedge clk)
            rst |=> !ea_valid) else $error("strobe after reset"); // R10
      end else begin : g_out_comb
         assign ea_valid  = take_ofs;
         assign ea_addr   = sum;
         assign ea_used_y = sel_y;
      end
   endgenerate
endmodule

// File: tb/idx_ea_gen_bench.sv
`timescale 1ns/1ps
module idx_ea_gen_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_in = 8'h00;
   logic        ld_x = 1'b0, ld_y = 1'b0, ld_b = 1'b0, abx_go = 1'b0;
   logic [15:0] ld_data = 16'h0000;
   logic        ea_valid;
   logic [15:0] ea_addr;
   logic        ea_used_y;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   idx_ea_gen u_idx_ea_gen (
      .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
      .ld_x(ld_x), .ld_y(ld_y), .ld_b(ld_b), .ld_data(ld_data), .abx_go(abx_go),
      .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_used_y(ea_used_y)
   );

   // fields: x[63:48] y[47:32] use_y[24] ofs[23:16] expected[15:0]
   localparam logic [63:0] VEC [8] = '{
      {16'h1000, 16'h0000, 8'h00, 8'h00, 16'h1000},
      {16'h1000, 16'h0000, 8'h00, 8'h22, 16'h1022},
      {16'h1234, 16'h0000, 8'h00, 8'hFF, 16'h1333},
      {16'hFFF0, 16'h0000, 8'h00, 8'h20, 16'h0010},
      {16'h0000, 16'h2000, 8'h01, 8'h07, 16'h2007},
      {16'h0000, 16'hFFFF, 8'h01, 8'hFF, 16'h00FE},
      {16'h0000, 16'h8000, 8'h01, 8'h00, 16'h8000},
      {16'h0000, 16'h0000, 8'h00, 8'h80, 16'h0080}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); byte_valid = 1'b1; byte_in = b;
      @(negedge clk); byte_valid = 1'b0;
   endtask

   task automatic load(input int which, input logic [15:0] v);
      @(negedge clk); ld_data = v;
      ld_x = (which == 0); ld_y = (which == 1); ld_b = (which == 2);
      @(negedge clk); ld_x = 1'b0; ld_y = 1'b0; ld_b = 1'b0;
   endtask

   // sends a full instruction; returns at the negedge where the strobe is visible
   task automatic instr(input bit use_y, input logic [7:0] ofs);
      if (use_y) put(8'h18);
      put(8'hA6);
      put(ofs);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset ea_valid", ea_valid, 0);
      rst = 1'b0;

      foreach (VEC[i]) begin
         load(0, VEC[i][63:48]);
         load(1, VEC[i][47:32]);
         instr(VEC[i][24], VEC[i][23:16]);
         chk("R1/R2/R6 ea_addr", ea_addr, VEC[i][15:0]);
         chk(VEC[i][24] ? "R5 used_y" : "R4 used_y", ea_used_y, VEC[i][24]);
         chk("R8 strobe high", ea_valid, 1);
         @(negedge clk);
         chk("R8 strobe one cycle", ea_valid, 0);
      end

      // R3: index unchanged by address formation
      load(0, 16'h4000);
      instr(1'b0, 8'h55);
      chk("R3 first ea", ea_addr, 16'h4055);
      instr(1'b0, 8'h00);
      chk("R3 x unchanged", ea_addr, 16'h4000);

      // R7: accumulator add with wrap
      load(0, 16'hFFF0);
      load(2, 16'h0020);
      @(negedge clk); abx_go = 1'b1;
      @(negedge clk); abx_go = 1'b0;
      instr(1'b0, 8'h00);
      chk("R7 abx wrap", ea_addr, 16'h0010);

      // R9: idle gaps between bytes
      load(0, 16'h0300);
      put(8'hA6);
      repeat (3) begin
         @(negedge clk);
         chk("R9 no strobe on idle", ea_valid, 0);
      end
      put(8'h04);
      chk("R9 strobe after gap", {15'd0, ea_valid}, 1);
      chk("R9 ea after gap", ea_addr, 16'h0304);

      // R5: prefix value in opcode position is an opcode
      load(1, 16'h7000);
      put(8'h18); put(8'h18);
      chk("R5 no strobe after second prefix value", ea_valid, 0);
      put(8'h09);
      chk("R5 three-byte y", {ea_used_y, ea_addr}, {1'b1, 16'h7009});

      // R10: reset drops a pending prefix
      put(8'h18);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R10 ea_valid cleared", ea_valid, 0);
      instr(1'b0, 8'h03);
      chk("R10 prefix dropped, x cleared", {ea_used_y, ea_addr}, {1'b0, 16'h0003});

      // R11: write in the same cycle as the displacement; load beats abx
      load(0, 16'h0100);
      load(2, 16'h0011);
      put(8'hA6);
      @(negedge clk);
      byte_valid = 1'b1; byte_in = 8'h10; ld_x = 1'b1; ld_data = 16'h5000; abx_go = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0; ld_x = 1'b0; abx_go = 1'b0;
      chk("R11 ea uses old x", ea_addr, 16'h0110);
      instr(1'b0, 8'h00);
      chk("R11 load beats abx", ea_addr, 16'h5000);

      finish_run();
   end
endmodule